// File: doc/BRIEF.md
# Infrared Pulse-Distance Message Decoder

This block turns a synchronised infrared receiver line into a data word. It measures how many clock cycles each mark (active level) and each space (idle level) lasts. A message must open with a leader mark and a leader space. After that, each mark and the space that follows it form one bit, and that pair is classified as a zero or a one against programmable windows. A space that reaches the programmed free-time minimum closes the message. If the message's bit count lies inside the accepted length range, the assembled word is published together with its bit count, a one-cycle valid strobe and the result of a masked data filter.

The controller is a five-state machine:
- `S_IDLE` waits for a mark to start (IDLE→LDR_MARK).
- `S_LDR_MARK` times the leader mark. When the mark ends it moves to LDR_SPACE if the mark fits its window, otherwise back to IDLE.
- `S_LDR_SPACE` times the leader space. When the next mark starts it moves to BIT_MARK and clears the word if the space fits its window, otherwise back to IDLE.
- `S_BIT_MARK` times a bit mark and always moves on to BIT_SPACE when the mark ends.
- `S_BIT_SPACE` either classifies the pair and returns to BIT_MARK when a mark starts, aborts to IDLE when the pair fits no window, or ends the message at the free-time limit and returns to IDLE.

Whenever the block is off, it returns to IDLE from any state. All durations are counted in clock cycles. A mark held for N sampling edges measures N.

Top module: `irpd_decoder`

## Requirements
- R1: The block decodes only while `code_sel` equals 1. With `code_sel` at 0, 2 or 3, `valid_o` never rises.
- R2: A message starts only after a leader mark inside the leader mark window and a leader space inside the leader space window. A leader that misses either window yields no output.
- R3: Each bit window vector packs four 16-bit fields: [15:0] mark minimum, [31:16] mark maximum, [47:32] space minimum, [63:48] space maximum. A pair whose mark and space both fit the zero fields is a 0. A pair whose mark and space both fit the one fields is a 1. Any other pair aborts the message with no output.
- R4: The message ends on the first cycle in which a space has lasted `free_min` cycles. It is accepted only if its bit count lies in [`len_min`, `len_max`].
- R5: With `act_high`=1 the mark level of `ir_in` is 1. With `act_high`=0 the mark level is 0.
- R6: With `msb_first`=0, the k-th received bit lands in word bit k. With `msb_first`=1, the first of n received bits lands in bit n-1 and the last lands in bit 0.
- R7: With `keep_bits`=1, bits are stored as received. With `keep_bits`=0, every bit is stored inverted.
- R8: `match_o` is 1 when ((word XOR `flt_data`) AND `flt_mask`) is zero and the bit count lies in [`flt_len_min`, `flt_len_max`].
- R9: While `enable` is 0 the block sits in IDLE and a partial message is dropped. The message is not completed after re-enabling.
- R10: For any range (window, length or filter length) whose maximum is below its minimum, only a value equal to the minimum matches.
- R11: The word holds 64 bits. Bits received after the 64th are dropped, and the count saturates at 64.
- R12: After reset the word, count, valid and match are 0. `valid_o` lasts one cycle per accepted message, and the word, count and match stay unchanged until the next accepted message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Decoder on |
| code_sel | input | 2 | Decoding style; only 1 (pulse-distance) acts |
| act_high | input | 1 | Mark level of the line (1 = high) |
| msb_first | input | 1 | Bit assembly order |
| keep_bits | input | 1 | 1 = store bits as received, 0 = invert |
| ir_in | input | 1 | Synchronised receiver line |
| ldr_win | input | 64 | Leader windows, field layout as in R3 |
| zero_win | input | 64 | Zero-bit windows |
| one_win | input | 64 | One-bit windows |
| free_min | input | 16 | Space length that ends a message |
| len_min | input | 7 | Minimum accepted bit count |
| len_max | input | 7 | Maximum accepted bit count |
| flt_data | input | 64 | Filter compare word |
| flt_mask | input | 64 | Filter bit mask |
| flt_len_min | input | 7 | Filter minimum bit count |
| flt_len_max | input | 7 | Filter maximum bit count |
| word_o | output | 64 | Last accepted word |
| count_o | output | 7 | Bit count of last accepted word |
| valid_o | output | 1 | One-cycle strobe per accepted message |
| match_o | output | 1 | Filter result for last accepted word |

## Verification
The hardest condition to reach from the ports is an abort in the middle of a message. It needs a correctly timed leader and several good bits, followed by either one space that sits just outside both bit windows or an enable drop partway through the bit train. Otherwise the damage is hidden by the rest of the train. The stimulus builds every message from mark/space durations given in cycles, so a single space can be stretched by one cycle past a window edge. It also lets the bench drop enable between two pairs and then still finish with a full trailing mark and free gap. The bench then confirms that no strobe appears.

// File: rtl/irpd_pkg.sv
package irpd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LDR_MARK,
        S_LDR_SPACE,
        S_BIT_MARK,
        S_BIT_SPACE
    } irpd_state_e;

    localparam logic [1:0] CODE_PULSE_DIST = 2'd1;

    localparam int SYM_LEADER = 0;
    localparam int SYM_ZERO   = 1;
    localparam int SYM_ONE    = 2;
    localparam int NUM_SYM    = 3;

endpackage

// File: rtl/irpd_window.sv
module irpd_window #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         hit
);

    always_comb begin
        if (hi < lo) begin
            hit = (val == lo);
        end else begin
            hit = (val >= lo) && (val <= hi);
        end
    end

endmodule

// File: rtl/irpd_runlen.sv
module irpd_runlen #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic             act_high,
    output logic             lvl,
    output logic             rise,
    output logic             fall,
    output logic [CNT_W-1:0] run_len
);

    localparam logic [CNT_W-1:0] RUN_MAX = '1;

    logic lvl_prev;

    assign lvl  = act_high ? line_in : ~line_in;
    assign rise = lvl & ~lvl_prev;
    assign fall = ~lvl & lvl_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev <= 1'b0;
            run_len  <= '0;
        end else begin
            lvl_prev <= lvl;
            if (lvl != lvl_prev) begin
                run_len <= CNT_W'(1);
            end else if (run_len != RUN_MAX) begin
                run_len <= run_len + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/irpd_assembler.sv
module irpd_assembler #(
    parameter int DATA_W = 64,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic              bit_in,
    input  logic              msb_first,
    input  logic              keep_bits,
    output logic [DATA_W-1:0] word,
    output logic [LEN_W-1:0]  count
);

    localparam int              IDX_W = $clog2(DATA_W);
    localparam logic [LEN_W-1:0] FULL = LEN_W'(DATA_W);

    logic stored;
    assign stored = keep_bits ? bit_in : ~bit_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            count <= '0;
        end else if (clr) begin
            word  <= '0;
            count <= '0;
        end else if (push && (count < FULL)) begin
            if (msb_first) begin
                word <= {word[DATA_W-2:0], stored};
            end else begin
                word[count[IDX_W-1:0]] <= stored;
            end
            count <= count + LEN_W'(1);
        end
    end

    a_r11_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);

endmodule

// File: rtl/irpd_decoder.sv
module irpd_decoder
    import irpd_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 64,
    parameter int LEN_W  = $clog2(DATA_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [1:0]         code_sel,
    input  logic               act_high,
    input  logic               msb_first,
    input  logic               keep_bits,
    input  logic               ir_in,
    input  logic [4*CNT_W-1:0] ldr_win,
    input  logic [4*CNT_W-1:0] zero_win,
    input  logic [4*CNT_W-1:0] one_win,
    input  logic [CNT_W-1:0]   free_min,
    input  logic [LEN_W-1:0]   len_min,
    input  logic [LEN_W-1:0]   len_max,
    input  logic [DATA_W-1:0]  flt_data,
    input  logic [DATA_W-1:0]  flt_mask,
    input  logic [LEN_W-1:0]   flt_len_min,
    input  logic [LEN_W-1:0]   flt_len_max,
    output logic [DATA_W-1:0]  word_o,
    output logic [LEN_W-1:0]   count_o,
    output logic               valid_o,
    output logic               match_o
);

    localparam int NUM_WIN = 2 * NUM_SYM;

    irpd_state_e state, state_n;

    logic               act;
    logic               lvl, rise, fall;
    logic [CNT_W-1:0]   run_len;
    logic [NUM_WIN-1:0] hit;
    logic [4*CNT_W-1:0] sym_win [NUM_SYM];
    logic               zm_ok, om_ok;
    logic               clr, push, push_bit, accept;
    logic [DATA_W-1:0]  asm_word;
    logic [LEN_W-1:0]   asm_count;
    logic               len_ok, flen_ok, flt_ok;

    assign act = enable && (code_sel == CODE_PULSE_DIST);

    irpd_runlen #(.CNT_W(CNT_W)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (ir_in),
        .act_high (act_high),
        .lvl      (lvl),
        .rise     (rise),
        .fall     (fall),
        .run_len  (run_len)
    );

    assign sym_win[SYM_LEADER] = ldr_win;
    assign sym_win[SYM_ZERO]   = zero_win;
    assign sym_win[SYM_ONE]    = one_win;

    // hit[2*s] checks a mark length, hit[2*s+1] a space length
    for (genvar s = 0; s < NUM_SYM; s++) begin : g_sym
        for (genvar h = 0; h < 2; h++) begin : g_half
            irpd_window #(.W(CNT_W)) u_win (
                .val (run_len),
                .lo  (sym_win[s][(2*h)*CNT_W +: CNT_W]),
                .hi  (sym_win[s][(2*h+1)*CNT_W +: CNT_W]),
                .hit (hit[2*s+h])
            );
        end
    end

    irpd_assembler #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (push),
        .bit_in    (push_bit),
        .msb_first (msb_first),
        .keep_bits (keep_bits),
        .word      (asm_word),
        .count     (asm_count)
    );

    irpd_window #(.W(LEN_W)) u_len (
        .val (asm_count),
        .lo  (len_min),
        .hi  (len_max),
        .hit (len_ok)
    );

    irpd_window #(.W(LEN_W)) u_flen (
        .val (asm_count),
        .lo  (flt_len_min),
        .hi  (flt_len_max),
        .hit (flen_ok)
    );

    assign flt_ok = flen_ok && (((asm_word ^ flt_data) & flt_mask) == '0);

    // next state and step controls
    always_comb begin
        state_n  = state;
        clr      = 1'b0;
        push     = 1'b0;
        push_bit = 1'b0;
        accept   = 1'b0;
        if (!act) begin
            state_n = S_IDLE;
            clr     = 1'b1;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (rise) state_n = S_LDR_MARK;
                end
                S_LDR_MARK: begin
                    if (fall) state_n = hit[2*SYM_LEADER] ? S_LDR_SPACE : S_IDLE;
                end
                S_LDR_SPACE: begin
                    if (rise) begin
                        if (hit[2*SYM_LEADER+1]) begin
                            state_n = S_BIT_MARK;
                            clr     = 1'b1;
                        end else begin
                            state_n = S_IDLE;
                        end
                    end
                end
                S_BIT_MARK: begin
                    if (fall) state_n = S_BIT_SPACE;
                end
                S_BIT_SPACE: begin
                    if (rise) begin
                        if (zm_ok && hit[2*SYM_ZERO+1]) begin
                            push    = 1'b1;
                            state_n = S_BIT_MARK;
                        end else if (om_ok && hit[2*SYM_ONE+1]) begin
                            push     = 1'b1;
                            push_bit = 1'b1;
                            state_n  = S_BIT_MARK;
                        end else begin
                            state_n = S_IDLE;
                        end
                    end else if (!lvl && (run_len >= free_min)) begin
                        accept  = len_ok;
                        state_n = S_IDLE;
                    end
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // mark classification kept until the space closes the pair
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zm_ok <= 1'b0;
            om_ok <= 1'b0;
        end else if ((state == S_BIT_MARK) && fall) begin
            zm_ok <= hit[2*SYM_ZERO];
            om_ok <= hit[2*SYM_ONE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o  <= '0;
            count_o <= '0;
            match_o <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= accept;
            if (accept) begin
                word_o  <= asm_word;
                count_o <= asm_count;
                match_o <= flt_ok;
            end
        end
    end

    a_r12_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r12_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(word_o) && $stable(count_o) && $stable(match_o)));

    a_r9_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == S_IDLE));

    a_r1_other_codes_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (code_sel != CODE_PULSE_DIST) |=> !valid_o);

    a_r11_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= LEN_W'(DATA_W));

endmodule

// File: tb/sim_irpd_decoder.sv
module sim_irpd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  code_sel = 2'd1;
    logic        act_high = 1'b1;
    logic        msb_first = 1'b0;
    logic        keep_bits = 1'b1;
    logic        ir_in = 1'b0;
    logic [63:0] ldr_win, zero_win, one_win;
    logic [15:0] free_min = 16'd12;
    logic [6:0]  len_min = 7'd0, len_max = 7'd64;
    logic [63:0] flt_data = '0, flt_mask = '0;
    logic [6:0]  flt_len_min = 7'd0, flt_len_max = 7'd64;
    logic [63:0] word_o;
    logic [6:0]  count_o;
    logic        valid_o, match_o;

    logic        mark_lvl = 1'b1;
    int          checks = 0;
    int          fails = 0;
    int          vcnt = 0;
    int          cyc = 0;
    logic [63:0] cap_word;
    logic [6:0]  cap_cnt;
    logic        cap_match;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    irpd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .code_sel(code_sel),
        .act_high(act_high), .msb_first(msb_first), .keep_bits(keep_bits),
        .ir_in(ir_in), .ldr_win(ldr_win), .zero_win(zero_win), .one_win(one_win),
        .free_min(free_min), .len_min(len_min), .len_max(len_max),
        .flt_data(flt_data), .flt_mask(flt_mask),
        .flt_len_min(flt_len_min), .flt_len_max(flt_len_max),
        .word_o(word_o), .count_o(count_o), .valid_o(valid_o), .match_o(match_o)
    );

    always @(negedge clk) begin
        if (valid_o) begin
            vcnt      = vcnt + 1;
            cap_word  = word_o;
            cap_cnt   = count_o;
            cap_match = match_o;
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL R12 watchdog actual=%0d expected<150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic inr(input int v, input int lo, input int hi);
        if (hi < lo) return v == lo;
        return (v >= lo) && (v <= hi);
    endfunction

    function automatic logic [63:0] exp_word(input int n, input logic [79:0] b,
                                             input logic msb, input logic keep);
        logic [63:0] w = '0;
        int k = (n > 64) ? 64 : n;
        for (int i = 0; i < k; i++) begin
            if (msb) w[k-1-i] = b[i] ^ ~keep;
            else     w[i]     = b[i] ^ ~keep;
        end
        return w;
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1103515245 + 32'd12345;
    endfunction

    task automatic drive(input logic mk, input int c);
        ir_in = mk ? mark_lvl : ~mark_lvl;
        repeat (c) @(negedge clk);
    endtask

    task automatic send(input int n, input logic [79:0] b, input int lm, input int ls, input int zsp);
        drive(1'b1, lm);
        drive(1'b0, ls);
        for (int i = 0; i < n; i++) begin
            drive(1'b1, 3);
            drive(1'b0, b[i] ? 7 : zsp);
        end
        drive(1'b1, 3);
        drive(1'b0, 18);
    endtask

    task automatic run_msg(input int n, input logic [79:0] b, input logic exp_valid,
                           input string req, input int lm, input int ls, input int zsp);
        logic [63:0] ew;
        int          ec;
        logic        em;
        vcnt = 0;
        send(n, b, lm, ls, zsp);
        repeat (4) @(negedge clk);
        check(vcnt == (exp_valid ? 1 : 0), {req, " strobe count"}, 64'(vcnt), exp_valid ? 64'd1 : 64'd0);
        if (exp_valid && vcnt == 1) begin
            ew = exp_word(n, b, msb_first, keep_bits);
            ec = (n > 64) ? 64 : n;
            em = (((ew ^ flt_data) & flt_mask) == '0) && inr(ec, int'(flt_len_min), int'(flt_len_max));
            check(cap_word == ew, {req, " word"}, cap_word, ew);
            check(int'(cap_cnt) == ec, {req, " count"}, 64'(cap_cnt), 64'(ec));
            check(cap_match == em, {req, " match"}, 64'(cap_match), 64'(em));
        end
    endtask

    function automatic logic [79:0] pattern();
        logic [79:0] p;
        seed = nxt(seed); p[31:0]  = seed;
        seed = nxt(seed); p[63:32] = seed;
        seed = nxt(seed); p[79:64] = seed[31:16];
        return p;
    endfunction

    initial begin
        logic [79:0] pat;
        logic [63:0] hold_w;
        logic [6:0]  hold_c;
        ldr_win  = {16'd10, 16'd6, 16'd18, 16'd14};
        zero_win = {16'd4, 16'd2, 16'd4, 16'd2};
        one_win  = {16'd8, 16'd6, 16'd4, 16'd2};
        repeat (5) @(negedge clk);
        // R12 reset state
        check(word_o == '0 && count_o == '0 && !valid_o && !match_o, "R12 reset",
              {word_o[55:0], count_o, valid_o}, 64'd0);
        rst_n = 1'b1;
        enable = 1'b1;
        repeat (3) @(negedge clk);

        // R4 R6 R7 R8 sweep over order, inversion, length and filter content
        flt_mask = 64'h0000_0000_0000_0F0F;
        for (int o = 0; o < 2; o++) begin
            for (int k = 0; k < 2; k++) begin
                msb_first = o[0];
                keep_bits = k[0];
                for (int n = 0; n <= 16; n++) begin
                    pat = pattern();
                    flt_data = exp_word(n, pat, msb_first, keep_bits) ^ ((n % 3 == 0) ? 64'h100 : 64'h0);
                    flt_len_min = 7'(n % 5);
                    flt_len_max = 7'd12;
                    run_msg(n, pat, 1'b1, "R6 R7 R8 R4 sweep", 16, 8, 3);
                end
            end
        end
        flt_mask = '0; flt_data = '0; flt_len_min = 7'd0; flt_len_max = 7'd64;
        msb_first = 1'b0; keep_bits = 1'b1;

        // R12 outputs held without a new message
        pat = pattern();
        run_msg(9, pat, 1'b1, "R12 base", 16, 8, 3);
        hold_w = word_o; hold_c = count_o; vcnt = 0;
        repeat (60) @(negedge clk);
        check(word_o == hold_w && count_o == hold_c && vcnt == 0, "R12 hold", word_o, hold_w);

        // R4 length range
        len_min = 7'd5; len_max = 7'd8;
        run_msg(4, pattern(), 1'b0, "R4 too short", 16, 8, 3);
        run_msg(9, pattern(), 1'b0, "R4 too long", 16, 8, 3);
        run_msg(5, pattern(), 1'b1, "R4 lower edge", 16, 8, 3);
        run_msg(8, pattern(), 1'b1, "R4 upper edge", 16, 8, 3);
        // R10 reversed length range
        len_min = 7'd6; len_max = 7'd2;
        run_msg(6, pattern(), 1'b1, "R10 exact length", 16, 8, 3);
        run_msg(7, pattern(), 1'b0, "R10 other length", 16, 8, 3);
        run_msg(2, pattern(), 1'b0, "R10 at max", 16, 8, 3);
        len_min = 7'd0; len_max = 7'd64;
        // R10 reversed space window on zero
        zero_win = {16'd0, 16'd3, 16'd4, 16'd2};
        run_msg(6, 80'h0, 1'b1, "R10 zero space exact", 16, 8, 3);
        run_msg(6, 80'h0, 1'b0, "R10 zero space off", 16, 8, 4);
        zero_win = {16'd4, 16'd2, 16'd4, 16'd2};

        // R2 leader windows
        run_msg(8, pattern(), 1'b0, "R2 short leader mark", 10, 8, 3);
        run_msg(8, pattern(), 1'b0, "R2 long leader mark", 19, 8, 3);
        run_msg(8, pattern(), 1'b0, "R2 long leader space", 16, 11, 3);
        run_msg(8, pattern(), 1'b0, "R2 short leader space", 16, 5, 3);
        run_msg(8, pattern(), 1'b1, "R2 leader edges", 14, 10, 3);

        // R3 bad bit space
        run_msg(8, 80'h0, 1'b0, "R3 space between windows", 16, 8, 5);
        run_msg(8, 80'h0, 1'b1, "R3 zero space edge", 16, 8, 4);

        // R1 code selection
        for (int c = 0; c < 4; c++) begin
            if (c != 1) begin
                code_sel = 2'(c);
                run_msg(7, pattern(), 1'b0, "R1 other code", 16, 8, 3);
            end
        end
        code_sel = 2'd1;

        // R9 enable dropped mid-message, and fully off
        vcnt = 0;
        drive(1'b1, 16); drive(1'b0, 8);
        for (int i = 0; i < 3; i++) begin drive(1'b1, 3); drive(1'b0, 7); end
        enable = 1'b0;
        drive(1'b1, 3); drive(1'b0, 3);
        enable = 1'b1;
        for (int i = 0; i < 3; i++) begin drive(1'b1, 3); drive(1'b0, 3); end
        drive(1'b1, 3); drive(1'b0, 18);
        repeat (4) @(negedge clk);
        check(vcnt == 0, "R9 partial dropped", 64'(vcnt), 64'd0);
        enable = 1'b0;
        run_msg(6, pattern(), 1'b0, "R9 disabled", 16, 8, 3);
        enable = 1'b1;
        run_msg(6, pattern(), 1'b1, "R9 re-enabled", 16, 8, 3);

        // R5 low-active line
        act_high = 1'b0; mark_lvl = 1'b0; ir_in = 1'b1;
        repeat (20) @(negedge clk);
        run_msg(11, pattern(), 1'b1, "R5 active low", 16, 8, 3);
        act_high = 1'b1; mark_lvl = 1'b1; ir_in = 1'b0;
        repeat (20) @(negedge clk);
        run_msg(11, pattern(), 1'b1, "R5 active high", 16, 8, 3);

        // R11 overlong messages
        msb_first = 1'b0;
        run_msg(70, pattern(), 1'b1, "R11 lsb saturate", 16, 8, 3);
        msb_first = 1'b1;
        run_msg(70, pattern(), 1'b1, "R11 msb saturate", 16, 8, 3);
        run_msg(64, pattern(), 1'b1, "R11 full word", 16, 8, 3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule